// File: doc/BRIEF.md
# Pipelined Quadratic Stream Evaluator

This block evaluates a second-order polynomial y = a*x^2 + b*x + c over a stream of signed samples x. The three coefficients come from configuration inputs that software sets while the stream is idle. One sample may enter on every clock cycle, marked by a valid flag, and each result leaves with its own valid flag a fixed three cycles later. There is no stall path.

The computation is split into three register-separated stages of similar depth. The first stage forms x*x and b*x. The second forms a*(x*x) and b*x + c. The third adds the two partial results. The clock period is therefore set by the slowest of these stages plus register overhead, and not by the whole multiply-multiply-add chain. All arithmetic is signed two's complement. Each intermediate is wide enough that no sample or coefficient value can overflow it.

Top module: `quad_stream_eval`

## Requirements
- R1: When a sample x is accepted with coefficients a, b, c, the matching result equals a*x*x + b*x + c exactly, as a signed two's-complement value of CW+2*XW+1 bits (49 bits at the defaults XW=16, CW=16).
- R2: A sample accepted at rising edge k (in_valid high at that edge) gives out_valid high, with its result on out_y, in the cycle that follows rising edge k+2. This is a latency of three registers.
- R3: Samples presented on consecutive cycles are all accepted. Their results come out on consecutive cycles in arrival order.
- R4: A cycle with in_valid low gives out_valid low three cycles later. It does not disturb the results of the samples around it.
- R5: While rst_n is low at a rising edge, every stage is emptied, so out_valid is low after that edge. Samples presented during reset, and samples still in flight when reset arrives, never produce a valid result.
- R6: The extreme values (x = -32768 or 32767, and coefficients at -32768 or 32767) give exact results with no wrap. The intermediate x*x is never negative.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset; clears the valid bits only |
| coef_a | input | CW | Signed coefficient of x^2; held stable while samples are in flight |
| coef_b | input | CW | Signed coefficient of x; held stable while samples are in flight |
| coef_c | input | CW | Signed constant term; held stable while samples are in flight |
| in_valid | input | 1 | High when in_x carries a sample to accept this cycle |
| in_x | input | XW | Signed input sample |
| out_valid | output | 1 | High when out_y carries a result |
| out_y | output | CW+2*XW+1 | Signed result a*x^2 + b*x + c |

## Verification
If a stage register is missing or duplicated, out_valid shifts off the three-cycle slot. The bench then flags this on the first valid sample after reset. A dropped sign extension or a truncated intermediate shows up as a wrong out_y. Random data reaches the top bits within a few samples, and the directed extreme values hit these cases at once. A valid bit that survives reset shows up as a stray out_valid within three cycles of reset being released.

// File: rtl/quad_pkg.sv
// Shared width defaults and the width rule for the quadratic evaluator.
// Assumes signed operands throughout.
package quad_pkg;
    localparam int QSE_XW = 16;
    localparam int QSE_CW = 16;

    // Result width that holds a*x^2 + b*x + c with no overflow.
    function automatic int qse_out_w(input int xw, input int cw);
        return cw + 2 * xw + 1;
    endfunction
endpackage

// File: rtl/qse_square_stage.sv
// Stage 1: registers x*x and b*x.
// Assumes coef_b is stable while the sample is in flight.
module qse_square_stage #(
    parameter int XW = 16,
    parameter int CW = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [XW-1:0]     in_x,
    input  logic signed [CW-1:0]     coef_b,
    output logic                     out_valid,
    output logic signed [2*XW-1:0]   out_sq,
    output logic signed [CW+XW-1:0]  out_bx
);
    localparam int SQW = 2 * XW;
    localparam int BXW = CW + XW;

    // Valid bit: cleared by reset, otherwise follows the input flag.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Data registers: sign-extended products, not reset.
    always_ff @(posedge clk) begin
        out_sq <= SQW'(in_x) * SQW'(in_x);
        out_bx <= BXW'(coef_b) * BXW'(in_x);
    end

    AST_SQUARE_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !out_sq[SQW-1]); // R6
endmodule

// File: rtl/qse_scale_stage.sv
// Stage 2: registers a*(x*x) and b*x + c.
// Assumes coef_a and coef_c are stable while the sample is in flight.
module qse_scale_stage #(
    parameter int XW = 16,
    parameter int CW = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic signed [2*XW-1:0]     in_sq,
    input  logic signed [CW+XW-1:0]    in_bx,
    input  logic signed [CW-1:0]       coef_a,
    input  logic signed [CW-1:0]       coef_c,
    output logic                       out_valid,
    output logic signed [CW+2*XW-1:0]  out_ax2,
    output logic signed [CW+XW:0]      out_bxc
);
    localparam int AXW = CW + 2 * XW;
    localparam int BCW = CW + XW + 1;

    // Valid bit: cleared by reset, otherwise follows stage 1.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Data registers: quadratic term and linear-plus-constant term.
    always_ff @(posedge clk) begin
        out_ax2 <= AXW'(coef_a) * AXW'(in_sq);
        out_bxc <= BCW'(in_bx) + BCW'(coef_c);
    end

    AST_QUAD_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !coef_a[CW-1]) |-> !out_ax2[AXW-1]); // R1
endmodule

// File: rtl/qse_sum_stage.sv
// Stage 3: registers the final sum of the two partial terms.
// Assumes the result width covers both operands plus one carry bit.
module qse_sum_stage #(
    parameter int XW = 16,
    parameter int CW = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic signed [CW+2*XW-1:0]  in_ax2,
    input  logic signed [CW+XW:0]      in_bxc,
    output logic                       out_valid,
    output logic signed [CW+2*XW:0]    out_y
);
    localparam int YW = quad_pkg::qse_out_w(XW, CW);

    // Valid bit: cleared by reset, otherwise follows stage 2.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Data register: full-width sum.
    always_ff @(posedge clk) begin
        out_y <= YW'(in_ax2) + YW'(in_bxc);
    end
endmodule

// File: rtl/quad_stream_eval.sv
// Top: three-stage pipelined evaluator of a*x^2 + b*x + c.
// Takes one sample per cycle and has a fixed latency of three cycles.
// Assumes coefficients change only while no sample is in flight.
module quad_stream_eval #(
    parameter int XW = quad_pkg::QSE_XW,
    parameter int CW = quad_pkg::QSE_CW
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [CW-1:0]     coef_a,
    input  logic signed [CW-1:0]     coef_b,
    input  logic signed [CW-1:0]     coef_c,
    input  logic                     in_valid,
    input  logic signed [XW-1:0]     in_x,
    output logic                     out_valid,
    output logic signed [CW+2*XW:0]  out_y
);
    localparam int YW = quad_pkg::qse_out_w(XW, CW);

    logic                      v1, v2;
    logic signed [2*XW-1:0]    sq1;
    logic signed [CW+XW-1:0]   bx1;
    logic signed [CW+2*XW-1:0] ax2_2;
    logic signed [CW+XW:0]     bxc2;

    qse_square_stage #(.XW(XW), .CW(CW)) u_s1 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x),
        .coef_b(coef_b), .out_valid(v1), .out_sq(sq1), .out_bx(bx1));

    qse_scale_stage #(.XW(XW), .CW(CW)) u_s2 (
        .clk(clk), .rst_n(rst_n), .in_valid(v1), .in_sq(sq1), .in_bx(bx1),
        .coef_a(coef_a), .coef_c(coef_c), .out_valid(v2),
        .out_ax2(ax2_2), .out_bxc(bxc2));

    qse_sum_stage #(.XW(XW), .CW(CW)) u_s3 (
        .clk(clk), .rst_n(rst_n), .in_valid(v2), .in_ax2(ax2_2),
        .in_bxc(bxc2), .out_valid(out_valid), .out_y(out_y));

    // Checking aid: counts edges since reset, saturating at three.
    logic [1:0] warm;
    always_ff @(posedge clk) begin
        if (!rst_n)            warm <= 2'd0;
        else if (warm != 2'd3) warm <= warm + 2'd1;
    end

    // Checking aid: direct evaluation of the polynomial at full width.
    function automatic logic signed [YW-1:0] ref_y(
        input logic signed [XW-1:0] x, input logic signed [CW-1:0] a,
        input logic signed [CW-1:0] b, input logic signed [CW-1:0] c);
        return YW'(a) * YW'(x) * YW'(x) + YW'(b) * YW'(x) + YW'(c);
    endfunction

    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd3) |-> (out_valid == $past(in_valid, 3))); // R2
    AST_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd3 && out_valid) |->
            (out_y == ref_y($past(in_x, 3), coef_a, coef_b, coef_c))); // R1
    AST_RESET_FLUSH: assert property (@(posedge clk)
        !rst_n |=> !out_valid); // R5
endmodule

// File: tb/test_quad_stream_eval.sv
`timescale 1ns/1ps
module test_quad_stream_eval;
    localparam int XW = 16;
    localparam int CW = 16;
    localparam int YW = CW + 2 * XW + 1;
    localparam int HN = 8192;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic                 rst_n;
    logic signed [CW-1:0] coef_a, coef_b, coef_c;
    logic                 in_valid;
    logic signed [XW-1:0] in_x;
    logic                 out_valid;
    logic signed [YW-1:0] out_y;

    quad_stream_eval #(.XW(XW), .CW(CW)) i_quad_stream_eval (
        .clk(clk), .rst_n(rst_n), .coef_a(coef_a), .coef_b(coef_b),
        .coef_c(coef_c), .in_valid(in_valid), .in_x(in_x),
        .out_valid(out_valid), .out_y(out_y));

    int     n_chk = 0, n_err = 0, n = 0;
    bit     done = 1'b0;
    bit     hv [HN];
    longint hy [HN];
    string  vtag = "R2", dtag = "R1";

    function automatic longint model(input longint a, b, c, x);
        return a * x * x + b * x + c;
    endfunction

    // One cycle: drive at the falling edge, record what is expected, then
    // check the output for the input accepted two rising edges earlier.
    task automatic cyc(input bit v, input logic signed [XW-1:0] x);
        in_valid = v;
        in_x     = x;
        hv[n] = v && rst_n;
        hy[n] = model(longint'(coef_a), longint'(coef_b), longint'(coef_c), longint'(x));
        if (!rst_n) begin
            if (n >= 1) hv[n-1] = 1'b0;
            if (n >= 2) hv[n-2] = 1'b0;
        end
        @(posedge clk);
        @(negedge clk);
        if (n >= 2) begin
            n_chk++;
            if (out_valid !== hv[n-2]) begin
                n_err++;
                $display("FAIL %s out_valid actual=%0b expected=%0b (step %0d)",
                         vtag, out_valid, hv[n-2], n);
            end
            if (hv[n-2]) begin
                n_chk++;
                if (longint'(out_y) !== hy[n-2]) begin
                    n_err++;
                    $display("FAIL %s out_y actual=%0d expected=%0d (step %0d)",
                             dtag, longint'(out_y), hy[n-2], n);
                end
            end
        end
        n++;
    endtask

    // Empty the pipeline, then load new coefficients.
    task automatic set_coefs(input logic signed [CW-1:0] a, b, c);
        for (int i = 0; i < 3; i++) cyc(1'b0, '0);
        coef_a = a; coef_b = b; coef_c = c;
    endtask

    initial begin
        #(8ns * 200000);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20250415);
        rst_n = 1'b0; in_valid = 1'b0; in_x = '0;
        coef_a = 16'sd3; coef_b = -16'sd5; coef_c = 16'sd7;
        @(negedge clk);

        // R5: valid samples during reset never come out.
        vtag = "R5";
        for (int i = 0; i < 4; i++) cyc(1'b1, XW'($urandom));
        rst_n = 1'b1;
        for (int i = 0; i < 3; i++) cyc(1'b0, '0);

        // R2: a single pulse appears after exactly three registers.
        vtag = "R2";
        cyc(1'b1, 16'sd3);
        for (int i = 0; i < 4; i++) cyc(1'b0, '0);
        cyc(1'b1, 16'sd0);        // R1: y equals c when x is zero
        for (int i = 0; i < 4; i++) cyc(1'b0, '0);

        // R3: back-to-back random stream under several coefficient sets.
        vtag = "R3";
        for (int blk = 0; blk < 4; blk++) begin
            set_coefs(CW'($urandom), CW'($urandom), CW'($urandom));
            for (int i = 0; i < 500; i++) cyc(1'b1, XW'($urandom));
        end

        // R4: random gaps in the stream.
        vtag = "R4";
        for (int blk = 0; blk < 3; blk++) begin
            set_coefs(CW'($urandom), CW'($urandom), CW'($urandom));
            for (int i = 0; i < 500; i++) cyc(1'($urandom), XW'($urandom));
        end

        // R6: extreme operands with no wrap.
        vtag = "R6"; dtag = "R6";
        set_coefs(-16'sd32768, -16'sd32768, 16'sd32767);
        cyc(1'b1, -16'sd32768); cyc(1'b1, 16'sd32767); cyc(1'b1, -16'sd1);
        cyc(1'b1, 16'sd1);      cyc(1'b1, 16'sd0);
        set_coefs(16'sd32767, 16'sd32767, -16'sd32768);
        cyc(1'b1, -16'sd32768); cyc(1'b1, 16'sd32767); cyc(1'b1, -16'sd32768);
        set_coefs(16'sd32767, -16'sd32768, 16'sd32767);
        cyc(1'b1, -16'sd32768); cyc(1'b1, 16'sd32767);

        // R5: reset in the middle of a stream flushes samples in flight.
        vtag = "R5"; dtag = "R1";
        set_coefs(16'sd11, -16'sd13, 16'sd17);
        for (int i = 0; i < 5; i++) cyc(1'b1, XW'($urandom));
        rst_n = 1'b0;
        cyc(1'b1, XW'($urandom));
        rst_n = 1'b1;
        for (int i = 0; i < 8; i++) cyc(1'b1, XW'($urandom));
        for (int i = 0; i < 4; i++) cyc(1'b0, '0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule